// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block turns a synchronous request port into the pin sequence that an external asynchronous SRAM-style device needs. Each accepted request becomes one access made of three timed phases: setup, then strobe, then hold. Chip select is low for all three phases. During the strobe phase the output enable (for a read) or the write enable (for a write) is pulsed low.

The length of every phase is taken from a set of timing inputs. Reads and writes each have their own setup, strobe and hold values. Each value is the phase length in clock cycles minus one, so a value of zero gives a one-cycle phase. The block samples these inputs only when it accepts a request, so software may change them freely while an access is running.

When the direction of an access differs from the previous one, the block inserts a programmable turnaround gap before the new setup phase. This gives the memory time to stop driving the bus before the controller drives it. The external data bus is split into an output, an input and a drive-enable, so a tri-state pad can be attached at the chip edge. Read data is captured at the end of the strobe phase and is reported with a one-cycle valid pulse after the hold phase.

Top module: `async_mem_strobe_ctrl`

## Requirements
- R1: After reset, mem_cs_n, mem_oe_n and mem_we_n are high, mem_data_oe and rd_valid are low, and req_ready is high.
- R2: An access shows a setup phase, then a strobe phase, then a hold phase. Each phase lasts its field value plus one clock cycles. mem_cs_n is low continuously across all three phases and high outside them.
- R3: A read takes its phase lengths from the read fields (cfg_rd_setup, cfg_rd_strobe, cfg_rd_hold). A write takes them from the write fields (cfg_wr_setup, cfg_wr_strobe, cfg_wr_hold). The fields of the other direction have no effect on it.
- R4: mem_oe_n is low exactly in the strobe cycles of a read, and mem_we_n is low exactly in the strobe cycles of a write. The two are never low together.
- R5: mem_addr and mem_bank equal the accepted request's address and bank, and they stay unchanged in every cycle that mem_cs_n is low.
- R6: In every chip-select cycle of a write, mem_data_oe is high and mem_data_out equals the request's write data. During reads and while idle, mem_data_oe is low.
- R7: rd_data takes the value of mem_data_in in the last strobe cycle of a read. rd_valid is high for exactly one cycle, the first cycle after the hold phase ends, and rd_data holds the captured value in that cycle.
- R8: req_ready is high only when the block is idle. A request is accepted on a clock edge where req_valid and req_ready are both high. req_ready stays low through an access and through a turnaround gap.
- R9: When a request's direction differs from the previous access, the block spends cfg_turn plus one extra cycles with mem_cs_n high before setup. A request already waiting therefore sees cfg_turn plus two high cycles between the two accesses. For the same direction, the gap is exactly one cycle.
- R10: Changing any timing input while an access is running does not change that access. The values present at acceptance apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address for the access |
| req_bank | input | 2 | Bank address for the access |
| req_wdata | input | 16 | Write data |
| cfg_rd_setup | input | 4 | Read setup length minus one |
| cfg_rd_strobe | input | 6 | Read strobe length minus one |
| cfg_rd_hold | input | 3 | Read hold length minus one |
| cfg_wr_setup | input | 4 | Write setup length minus one |
| cfg_wr_strobe | input | 6 | Write strobe length minus one |
| cfg_wr_hold | input | 3 | Write hold length minus one |
| cfg_turn | input | 2 | Turnaround gap length minus one |
| rd_valid | output | 1 | One-cycle pulse: read data ready |
| rd_data | output | 16 | Captured read data |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_addr | output | 22 | External address |
| mem_bank | output | 2 | External bank address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_data_out | output | 16 | Data driven toward the memory |
| mem_data_oe | output | 1 | Drive enable for the data pad |
| mem_data_in | input | 16 | Data returned from the memory pad |

## Verification
The shared phase counter is the state most likely to go wrong. An error in it shows up in the very access where it happens, as a setup, strobe or hold phase that is one or more cycles off. It also moves the read capture point, which is visible when the memory model returns the correct word only in the last strobe cycle. A wrong direction latch is visible in the first strobe cycle, because the wrong enable pin falls or the data pad drives during a read. Wrong turnaround bookkeeping only appears on the next request, as a gap of the wrong length between two chip-select runs.

// File: rtl/amc_pkg.sv
package amc_pkg;

  // Default pin and field widths for the controller.
  localparam int AMC_ADDR_W   = 22;
  localparam int AMC_BANK_W   = 2;
  localparam int AMC_DATA_W   = 16;
  localparam int AMC_SETUP_W  = 4;
  localparam int AMC_STROBE_W = 6;
  localparam int AMC_HOLD_W   = 3;
  localparam int AMC_TURN_W   = 2;

  // Sequencer phases.
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_TURN   = 3'd1,
    PH_SETUP  = 3'd2,
    PH_STROBE = 3'd3,
    PH_HOLD   = 3'd4
  } amc_phase_e;

endpackage

// File: rtl/amc_rst_sync.sv
module amc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  // Reset asserts asynchronously and is released synchronously.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/amc_phase_counter.sv
module amc_phase_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/amc_sequencer.sv
module amc_sequencer
  import amc_pkg::*;
#(
  parameter int SETUP_W  = AMC_SETUP_W,
  parameter int STROBE_W = AMC_STROBE_W,
  parameter int HOLD_W   = AMC_HOLD_W,
  parameter int TURN_W   = AMC_TURN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [SETUP_W-1:0]  cfg_rd_setup,
  input  logic [STROBE_W-1:0] cfg_rd_strobe,
  input  logic [HOLD_W-1:0]   cfg_rd_hold,
  input  logic [SETUP_W-1:0]  cfg_wr_setup,
  input  logic [STROBE_W-1:0] cfg_wr_strobe,
  input  logic [HOLD_W-1:0]   cfg_wr_hold,
  input  logic [TURN_W-1:0]   cfg_turn,
  output logic                req_ready,
  output logic                accept,
  output logic                capture,
  output logic                active,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic                mem_data_oe,
  output logic                rd_valid
);

  localparam int W_A   = (SETUP_W > STROBE_W) ? SETUP_W : STROBE_W;
  localparam int W_B   = (HOLD_W > TURN_W) ? HOLD_W : TURN_W;
  localparam int CNT_W = (W_A > W_B) ? W_A : W_B;

  amc_phase_e          phase_q, phase_d;
  logic                wr_q, have_prev_q;
  logic [SETUP_W-1:0]  setup_q;
  logic [STROBE_W-1:0] strobe_q;
  logic [HOLD_W-1:0]   hold_q;
  logic                cnt_load, cnt_zero;
  logic [CNT_W-1:0]    cnt_val;
  logic                dir_d, on_bus_d;
  logic                cs_n_q, oe_n_q, we_n_q, doe_q, ready_q, rdv_q;

  amc_phase_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .zero     (cnt_zero)
  );

  assign accept  = req_valid && (phase_q == PH_IDLE);
  assign capture = (phase_q == PH_STROBE) && cnt_zero && !wr_q;

  // Next-state decode.
  always_comb begin
    phase_d  = phase_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          cnt_load = 1'b1;
          if (have_prev_q && (req_write != wr_q)) begin
            phase_d = PH_TURN;
            cnt_val = CNT_W'(cfg_turn);
          end else begin
            phase_d = PH_SETUP;
            cnt_val = req_write ? CNT_W'(cfg_wr_setup) : CNT_W'(cfg_rd_setup);
          end
        end
      end
      PH_TURN: if (cnt_zero) begin
        phase_d  = PH_SETUP;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(setup_q);
      end
      PH_SETUP: if (cnt_zero) begin
        phase_d  = PH_STROBE;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(strobe_q);
      end
      PH_STROBE: if (cnt_zero) begin
        phase_d  = PH_HOLD;
        cnt_load = 1'b1;
        cnt_val  = CNT_W'(hold_q);
      end
      PH_HOLD: if (cnt_zero) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  assign dir_d    = accept ? req_write : wr_q;
  assign on_bus_d = (phase_d == PH_SETUP) || (phase_d == PH_STROBE) ||
                    (phase_d == PH_HOLD);

  // State and registered pin controls.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      wr_q        <= 1'b0;
      have_prev_q <= 1'b0;
      setup_q     <= '0;
      strobe_q    <= '0;
      hold_q      <= '0;
      cs_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      we_n_q      <= 1'b1;
      doe_q       <= 1'b0;
      ready_q     <= 1'b1;
      rdv_q       <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cs_n_q  <= !on_bus_d;
      oe_n_q  <= !((phase_d == PH_STROBE) && !dir_d);
      we_n_q  <= !((phase_d == PH_STROBE) && dir_d);
      doe_q   <= on_bus_d && dir_d;
      ready_q <= (phase_d == PH_IDLE);
      rdv_q   <= (phase_q == PH_HOLD) && cnt_zero && !wr_q;
      if (accept) begin
        wr_q        <= req_write;
        have_prev_q <= 1'b1;
        setup_q     <= req_write ? cfg_wr_setup  : cfg_rd_setup;
        strobe_q    <= req_write ? cfg_wr_strobe : cfg_rd_strobe;
        hold_q      <= req_write ? cfg_wr_hold   : cfg_rd_hold;
      end
    end
  end

  assign mem_cs_n    = cs_n_q;
  assign mem_oe_n    = oe_n_q;
  assign mem_we_n    = we_n_q;
  assign mem_data_oe = doe_q;
  assign req_ready   = ready_q;
  assign rd_valid    = rdv_q;
  assign active      = !cs_n_q;

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n_q |-> (!cs_n_q && we_n_q));
  // R4
  wstrobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_q |-> (!cs_n_q && oe_n_q));
  // R6
  drive_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doe_q |-> (!cs_n_q && oe_n_q));
  // R7
  rdv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |=> !rdv_q);
  // R7
  rdv_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdv_q |-> (cs_n_q && $past(!cs_n_q)));
  // R8
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_q |-> !ready_q);

endmodule

// File: rtl/amc_datapath.sv
module amc_datapath #(
  parameter int ADDR_W = 22,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic              active,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_data_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [BANK_W-1:0] mem_bank,
  output logic [DATA_W-1:0] mem_data_out,
  output logic [DATA_W-1:0] rd_data
);

  logic [ADDR_W-1:0] addr_q;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      bank_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      bank_q  <= req_bank;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_data_in;
  end

  assign mem_addr     = addr_q;
  assign mem_bank     = bank_q;
  assign mem_data_out = wdata_q;
  assign rd_data      = rdata_q;

  // R5
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> ($stable(addr_q) && $stable(bank_q) && $stable(wdata_q)));
  // R7
  no_capture_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> active);

endmodule

// File: rtl/async_mem_strobe_ctrl.sv
module async_mem_strobe_ctrl
  import amc_pkg::*;
#(
  parameter int ADDR_W   = AMC_ADDR_W,
  parameter int BANK_W   = AMC_BANK_W,
  parameter int DATA_W   = AMC_DATA_W,
  parameter int SETUP_W  = AMC_SETUP_W,
  parameter int STROBE_W = AMC_STROBE_W,
  parameter int HOLD_W   = AMC_HOLD_W,
  parameter int TURN_W   = AMC_TURN_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BANK_W-1:0]   req_bank,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [SETUP_W-1:0]  cfg_rd_setup,
  input  logic [STROBE_W-1:0] cfg_rd_strobe,
  input  logic [HOLD_W-1:0]   cfg_rd_hold,
  input  logic [SETUP_W-1:0]  cfg_wr_setup,
  input  logic [STROBE_W-1:0] cfg_wr_strobe,
  input  logic [HOLD_W-1:0]   cfg_wr_hold,
  input  logic [TURN_W-1:0]   cfg_turn,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                mem_cs_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [BANK_W-1:0]   mem_bank,
  output logic                mem_oe_n,
  output logic                mem_we_n,
  output logic [DATA_W-1:0]   mem_data_out,
  output logic                mem_data_oe,
  input  logic [DATA_W-1:0]   mem_data_in
);

  logic rst_sync_n;
  logic accept, capture, active;

  amc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  amc_sequencer #(
    .SETUP_W  (SETUP_W),
    .STROBE_W (STROBE_W),
    .HOLD_W   (HOLD_W),
    .TURN_W   (TURN_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .cfg_rd_setup  (cfg_rd_setup),
    .cfg_rd_strobe (cfg_rd_strobe),
    .cfg_rd_hold   (cfg_rd_hold),
    .cfg_wr_setup  (cfg_wr_setup),
    .cfg_wr_strobe (cfg_wr_strobe),
    .cfg_wr_hold   (cfg_wr_hold),
    .cfg_turn      (cfg_turn),
    .req_ready     (req_ready),
    .accept        (accept),
    .capture       (capture),
    .active        (active),
    .mem_cs_n      (mem_cs_n),
    .mem_oe_n      (mem_oe_n),
    .mem_we_n      (mem_we_n),
    .mem_data_oe   (mem_data_oe),
    .rd_valid      (rd_valid)
  );

  amc_datapath #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .accept       (accept),
    .capture      (capture),
    .active       (active),
    .req_addr     (req_addr),
    .req_bank     (req_bank),
    .req_wdata    (req_wdata),
    .mem_data_in  (mem_data_in),
    .mem_addr     (mem_addr),
    .mem_bank     (mem_bank),
    .mem_data_out (mem_data_out),
    .rd_data      (rd_data)
  );

endmodule

// File: tb/sim_async_mem_strobe_ctrl.sv
`timescale 1ns/1ps
module sim_async_mem_strobe_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [21:0] req_addr;
  logic [1:0]  req_bank;
  logic [15:0] req_wdata;
  logic [3:0]  cfg_rd_setup, cfg_wr_setup;
  logic [5:0]  cfg_rd_strobe, cfg_wr_strobe;
  logic [2:0]  cfg_rd_hold, cfg_wr_hold;
  logic [1:0]  cfg_turn;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        mem_cs_n, mem_oe_n, mem_we_n, mem_data_oe;
  logic [21:0] mem_addr;
  logic [1:0]  mem_bank;
  logic [15:0] mem_data_out, mem_data_in, mem_rd_val;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  // Memory model: drives the stored word only while output enable is low.
  assign mem_data_in = mem_oe_n ? 16'hDEAD : mem_rd_val;

  async_mem_strobe_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_bank(req_bank),
    .req_wdata(req_wdata), .cfg_rd_setup(cfg_rd_setup),
    .cfg_rd_strobe(cfg_rd_strobe), .cfg_rd_hold(cfg_rd_hold),
    .cfg_wr_setup(cfg_wr_setup), .cfg_wr_strobe(cfg_wr_strobe),
    .cfg_wr_hold(cfg_wr_hold), .cfg_turn(cfg_turn), .rd_valid(rd_valid),
    .rd_data(rd_data), .mem_cs_n(mem_cs_n), .mem_addr(mem_addr),
    .mem_bank(mem_bank), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_data_out(mem_data_out), .mem_data_oe(mem_data_oe),
    .mem_data_in(mem_data_in)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int rs, input int rt, input int rh,
                         input int ws, input int wt, input int wh, input int ta);
    cfg_rd_setup  = 4'(rs); cfg_rd_strobe = 6'(rt); cfg_rd_hold = 3'(rh);
    cfg_wr_setup  = 4'(ws); cfg_wr_strobe = 6'(wt); cfg_wr_hold = 3'(wh);
    cfg_turn      = 2'(ta);
  endtask

  // Called at a falling edge; returns at the falling edge after acceptance.
  task automatic issue(input bit wr, input logic [21:0] a, input logic [1:0] b,
                       input logic [15:0] d);
    bit r;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_bank = b; req_wdata = d;
    do begin
      r = req_ready;
      @(negedge clk);
    end while (!r);
    req_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk(mem_cs_n == 1'b1,    "R1", "cs_n after reset", mem_cs_n, 1);
    chk(mem_oe_n == 1'b1,    "R1", "oe_n after reset", mem_oe_n, 1);
    chk(mem_we_n == 1'b1,    "R1", "we_n after reset", mem_we_n, 1);
    chk(mem_data_oe == 1'b0, "R1", "data_oe after reset", mem_data_oe, 0);
    chk(req_ready == 1'b1,   "R1", "ready after reset", req_ready, 1);
    chk(rd_valid == 1'b0,    "R1", "rd_valid after reset", rd_valid, 0);
  endtask

  // One access; checks phase lengths (R2, R3), strobes (R4), address (R5),
  // data drive (R6), read capture (R7), ready (R8), config freeze (R10).
  task automatic single_access(input bit wr, input logic [21:0] a, input logic [1:0] b,
                               input logic [15:0] d, input int rs, input int rt,
                               input int rh, input int ws, input int wt, input int wh,
                               input bit chg);
    int ns = 0, nt = 0, nh = 0;
    int bad_stb = 0, bad_bus = 0, bad_drv = 0, bad_rdy = 0, rdv_early = 0;
    int es, et, eh;
    bit done = 0;
    string rq;
    es = wr ? ws : rs; et = wr ? wt : rt; eh = wr ? wh : rh;
    rq = chg ? "R10" : "R2/R3";
    set_cfg(rs, rt, rh, ws, wt, wh, 0);
    mem_rd_val = ~d;
    issue(wr, a, b, d);
    if (chg) set_cfg(15, 63, 7, 15, 63, 7, 3);
    for (int i = 0; i < 400 && !done; i++) begin
      if (!mem_cs_n) begin
        bit stb;
        stb = wr ? !mem_we_n : !mem_oe_n;
        if (wr ? !mem_oe_n : !mem_we_n) bad_stb++;
        if (stb) nt++;
        else if (nt == 0) ns++;
        else nh++;
        if (mem_addr != a || mem_bank != b) bad_bus++;
        if (mem_data_oe != wr || (wr && mem_data_out != d)) bad_drv++;
        if (req_ready) bad_rdy++;
        if (rd_valid) rdv_early++;
        mem_rd_val = (!wr && stb && nt == et + 1) ? d : ~d;
      end else if (ns + nt + nh > 0) begin
        done = 1;
      end else if (mem_data_oe) begin
        bad_drv++;
      end
      if (!done) @(negedge clk);
    end
    chk(done,       rq,   "access completed", done, 1);
    chk(ns == es + 1, rq, "setup cycles", ns, es + 1);
    chk(nt == et + 1, rq, "strobe cycles", nt, et + 1);
    chk(nh == eh + 1, rq, "hold cycles", nh, eh + 1);
    chk(bad_stb == 0, "R4", "wrong strobe cycles", bad_stb, 0);
    chk(bad_bus == 0, "R5", "address/bank mismatches", bad_bus, 0);
    chk(bad_drv == 0, "R6", "data drive mismatches", bad_drv, 0);
    chk(bad_rdy == 0, "R8", "ready high during access", bad_rdy, 0);
    chk(rdv_early == 0, "R7", "rd_valid during access", rdv_early, 0);
    chk(mem_data_oe == 1'b0, "R6", "data_oe after access", mem_data_oe, 0);
    chk(rd_valid == !wr, "R7", "rd_valid after hold", rd_valid, !wr);
    if (!wr) chk(rd_data == d, "R7", "captured read data", rd_data, d);
    @(negedge clk);
    chk(rd_valid == 1'b0, "R7", "rd_valid pulse width", rd_valid, 0);
    chk(req_ready == 1'b1, "R8", "ready when idle", req_ready, 1);
  endtask

  // Two accesses back to back; measures chip-select-high gap (R9, R8).
  task automatic gap_test(input bit wr1, input bit wr2, input int ta, input int exp_gap);
    int gap = 0, rdy_hi = 0, stage = 0;
    bit drop = 0;
    set_cfg(0, 0, 0, 0, 0, 0, ta);
    issue(wr1, 22'h00_0011, 2'd1, 16'h1111);
    req_valid = 1'b1; req_write = wr2; req_addr = 22'h2A_5522; req_bank = 2'd2;
    req_wdata = 16'h2222;
    for (int i = 0; i < 100 && stage < 3; i++) begin
      if (stage == 0 && !mem_cs_n) stage = 1;
      else if (stage == 1 && mem_cs_n) stage = 2;
      if (stage == 2) begin
        if (!mem_cs_n) stage = 3;
        else begin
          gap++;
          if (req_ready) rdy_hi++;
        end
      end
      if (req_valid && req_ready) drop = 1;
      @(negedge clk);
      if (drop) begin req_valid = 1'b0; drop = 0; end
    end
    req_valid = 1'b0;
    chk(stage == 3, "R9", "second access started", stage, 3);
    chk(gap == exp_gap, "R9", "chip select gap", gap, exp_gap);
    chk(rdy_hi == 1, "R8", "ready cycles in gap", rdy_hi, 1);
    while (!mem_cs_n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_bank = '0;
    req_wdata = '0; mem_rd_val = '0;
    set_cfg(0, 0, 0, 0, 0, 0, 0);
    repeat (4) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    // R2 R4 R7: minimal read and write
    single_access(1'b0, 22'h12_3456, 2'd3, 16'hA55A, 0, 0, 0, 5, 5, 5, 1'b0);
    single_access(1'b1, 22'h3F_FFFF, 2'd0, 16'hC3C3, 4, 4, 4, 0, 0, 0, 1'b0);
    // R3: other direction's fields must not matter
    single_access(1'b0, 22'h01_0203, 2'd1, 16'h0F0F, 3, 5, 2, 9, 1, 6, 1'b0);
    single_access(1'b1, 22'h2A_AAAA, 2'd2, 16'h8001, 7, 20, 4, 2, 4, 1, 1'b0);
    // R2: maximum field values
    single_access(1'b0, 22'h15_5555, 2'd1, 16'h7E81, 15, 63, 7, 0, 0, 0, 1'b0);
    // R10: fields changed mid access
    single_access(1'b1, 22'h00_0001, 2'd3, 16'hBEEF, 0, 0, 0, 1, 2, 3, 1'b1);
    single_access(1'b0, 22'h00_0002, 2'd0, 16'h1234, 2, 3, 1, 0, 0, 0, 1'b1);
    // R9: turnaround only on direction change
    gap_test(1'b0, 1'b1, 2, 4);
    gap_test(1'b1, 1'b0, 0, 2);
    gap_test(1'b0, 1'b1, 3, 5);
    gap_test(1'b1, 1'b1, 3, 1);
    gap_test(1'b0, 1'b0, 3, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule